// File: doc/BRIEF.md
# Daisy-Chained Token Readout Sequencer

This block is the per-chip readout sequencer for a string of front-end chips that all drive one shared serial data line. It steps the chip through its operating modes: acquisition, then conversion, then an idle wait. From that wait it accepts a start token from the upstream neighbour, or from the acquisition system for the first chip. While it holds the token it is the only chip allowed to drive the shared line. It raises a transmit-enable for exactly as long as it drives the line, shifts out a frame, and then sends a one-cycle token pulse to the downstream chip.

Each frame opens with the chip's 8-bit identifier. The stored events follow in storage order. For each event the frame carries its 4-bit index, then the word read from the event memory through a simple address/data read port. A chip that stores no events still takes the token, but hands it on in the next cycle without driving the line. Once the token has been passed, the chip ignores further tokens until a new acquisition begins.

Top module: `chain_readout_ctrl`

## Requirements
- R1: While reset is asserted and right after it, `mode` is 0 (idle), and `tx_on`, `sdata` and `token_out` are all 0.
- R2: `mode` takes the codes 0 = idle, 1 = acquisition, 2 = conversion, 3 = transmitting. In idle, an `acq_start` pulse gives mode 1 in the next cycle. In acquisition, `acq_stop` gives mode 2 in the next cycle. In conversion, `conv_done` gives mode 0 in the next cycle, and the chip is then armed for the token.
- R3: A `token_in` pulse has no effect unless the chip is armed. This covers idle before any acquisition, acquisition and conversion: `tx_on` and `token_out` stay 0 and `mode` is unchanged.
- R4: When `token_in` arrives at an armed chip whose `ev_count` is 0, `token_out` is 1 in the next cycle and `tx_on` never rises.
- R5: When `token_in` arrives at an armed chip with N > 0 events, `tx_on` is 1 from the next cycle. It stays 1 for exactly 8 + 21·N consecutive cycles, and `mode` is 3 throughout.
- R6: The first 8 bits of a frame on `sdata` are `chip_id`, most significant bit first.
- R7: After the identifier come the events 0..N-1 in order, 21 bits each, MSB first. Each event is its 4-bit index followed by the 17-bit word that `mem_rd_data` returns for `mem_addr` equal to that index. The top bit of that word is the gain bit, sent first.
- R8: `token_out` is a single-cycle pulse in the cycle right after the last transmitted bit. After it, `token_in` is ignored until a new acquisition.
- R9: `sdata` is 0 whenever `tx_on` is 0.
- R10: An `ev_count` above 16 is treated as 16.
- R11: Each new acquisition/conversion cycle re-arms the chip for another full readout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acq_start | input | 1 | Begin acquisition (pulse) |
| acq_stop | input | 1 | End acquisition, begin conversion (pulse) |
| conv_done | input | 1 | Conversion finished, arm for readout (pulse) |
| token_in | input | 1 | Start-of-readout token from upstream |
| token_out | output | 1 | End-of-readout token toward downstream |
| chip_id | input | 8 | Identifier placed at the head of each frame |
| ev_count | input | 5 | Number of stored events (0..16, larger clamps) |
| mem_addr | output | 4 | Event memory read address |
| mem_rd_data | input | 17 | Event word: gain bit then 4 channel values of 4 bits |
| tx_on | output | 1 | High while this chip drives the shared line |
| sdata | output | 1 | Serial data bit |
| mode | output | 2 | Operating mode code |

## Verification
The in-line assertions watch, on every cycle, the properties that are local in time. They check that the output token lasts one cycle, that transmission starts only right after a token arrives, that the end of transmission is followed by the token, that the line stays quiet when not enabled, and that the event cursor stays within the clamped count. Frame length, the bit order and content of the identifier and events, and the ignoring of tokens in the wrong mode or after hand-off can only be shown by the bench. It sweeps every event count from 0 to 16 plus an over-range value, with varied identifiers and memory contents.

// File: rtl/ro_pkg.sv
package ro_pkg;

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_ACQ   = 3'd1,
    S_CONV  = 3'd2,
    S_ARMED = 3'd3,
    S_HDR   = 3'd4,
    S_EVT   = 3'd5,
    S_PASS  = 3'd6
  } ro_state_e;

  typedef enum logic [1:0] {
    MODE_IDLE = 2'd0,
    MODE_ACQ  = 2'd1,
    MODE_CONV = 2'd2,
    MODE_DAQ  = 2'd3
  } ro_mode_e;

endpackage

// File: rtl/ro_seq_fsm.sv
module ro_seq_fsm
  import ro_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       acq_start,
  input  logic       acq_stop,
  input  logic       conv_done,
  input  logic       token_in,
  input  logic       ev_zero,
  input  logic       last_bit,
  input  logic       last_event,
  output logic       load_hdr,
  output logic       load_evt,
  output logic       shift_en,
  output logic       tx_on,
  output logic       token_out,
  output logic [1:0] mode
);

  ro_state_e state_q, state_d;
  logic      in_frame;

  assign in_frame = (state_q == S_HDR) || (state_q == S_EVT);

  // next-state logic
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:  if (acq_start) state_d = S_ACQ;
      S_ACQ:   if (acq_stop)  state_d = S_CONV;
      S_CONV:  if (conv_done) state_d = S_ARMED;
      S_ARMED: if (token_in)  state_d = ev_zero ? S_PASS : S_HDR;
      S_HDR:   if (last_bit)  state_d = S_EVT;
      S_EVT:   if (last_bit && last_event) state_d = S_PASS;
      S_PASS:  state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  // state register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= S_IDLE;
    else        state_q <= state_d;
  end

  // datapath controls
  assign load_hdr = (state_q == S_ARMED) && token_in && !ev_zero;
  assign load_evt = last_bit &&
                    ((state_q == S_HDR) || ((state_q == S_EVT) && !last_event));
  assign shift_en = in_frame && !last_bit;

  assign tx_on     = in_frame;
  assign token_out = (state_q == S_PASS);

  always_comb begin
    unique case (state_q)
      S_ACQ:        mode = MODE_ACQ;
      S_CONV:       mode = MODE_CONV;
      S_HDR, S_EVT: mode = MODE_DAQ;
      default:      mode = MODE_IDLE;
    endcase
  end

  // R8: the downstream token is a one-cycle pulse
  p_token_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    token_out |=> !token_out);

  // R5: transmission only starts right after a token was seen
  p_tx_after_token_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_on) |-> $past(token_in));

  // R8: end of transmission hands the token on at once
  p_pass_after_tx_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_on) |-> token_out);

endmodule

// File: rtl/ro_event_cursor.sv
module ro_event_cursor #(
  parameter int MAX_EV = 16,
  localparam int IDX_W = $clog2(MAX_EV),
  localparam int CNT_W = $clog2(MAX_EV + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_hdr,
  input  logic             load_evt,
  input  logic [CNT_W-1:0] ev_count,
  output logic [IDX_W-1:0] rd_idx,
  output logic             last_event
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] addr_q, addr_d;
  logic [CNT_W-1:0] cnt_clamped;

  assign cnt_clamped = (ev_count > CNT_W'(MAX_EV)) ? CNT_W'(MAX_EV) : ev_count;

  // next-state logic: addr_q always points at the event to load next
  always_comb begin
    cnt_d  = cnt_q;
    addr_d = addr_q;
    if (load_hdr) begin
      cnt_d  = cnt_clamped;
      addr_d = '0;
    end else if (load_evt) begin
      addr_d = addr_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      addr_q <= '0;
    end else if (load_hdr || load_evt) begin
      cnt_q  <= cnt_d;
      addr_q <= addr_d;
    end
  end

  assign rd_idx     = addr_q[IDX_W-1:0];
  assign last_event = (addr_q == cnt_q);

  // R10: stored count never exceeds the memory depth
  p_cnt_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(MAX_EV));

  // R7: the cursor never runs past the stored count
  p_addr_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    addr_q <= cnt_q);

endmodule

// File: rtl/ro_bit_shifter.sv
module ro_bit_shifter #(
  parameter int ID_W = 8,
  parameter int EV_W = 21,
  localparam int SH_W = (EV_W > ID_W) ? EV_W : ID_W,
  localparam int BC_W = $clog2(SH_W)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_hdr,
  input  logic            load_evt,
  input  logic            shift_en,
  input  logic            tx_on,
  input  logic [ID_W-1:0] hdr_word,
  input  logic [EV_W-1:0] evt_word,
  output logic            last_bit,
  output logic            sdata
);

  logic [SH_W-1:0] sh_q, sh_d;
  logic [BC_W-1:0] bc_q, bc_d;

  // next-state logic: words are loaded MSB-aligned, shifted left
  always_comb begin
    sh_d = sh_q;
    bc_d = bc_q;
    if (load_hdr) begin
      sh_d = SH_W'(hdr_word) << (SH_W - ID_W);
      bc_d = BC_W'(ID_W - 1);
    end else if (load_evt) begin
      sh_d = SH_W'(evt_word) << (SH_W - EV_W);
      bc_d = BC_W'(EV_W - 1);
    end else if (shift_en) begin
      sh_d = sh_q << 1;
      bc_d = bc_q - BC_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
      bc_q <= '0;
    end else if (load_hdr || load_evt || shift_en) begin
      sh_q <= sh_d;
      bc_q <= bc_d;
    end
  end

  assign last_bit = (bc_q == '0);
  assign sdata    = tx_on & sh_q[SH_W-1];

  // R9: the shared line stays low while not enabled
  p_quiet_bus_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_on |-> !sdata);

endmodule

// File: rtl/chain_readout_ctrl.sv
module chain_readout_ctrl #(
  parameter int MAX_EV = 16,
  parameter int N_CH   = 4,
  parameter int VAL_W  = 4,
  parameter int ID_W   = 8,
  localparam int IDX_W  = $clog2(MAX_EV),
  localparam int CNT_W  = $clog2(MAX_EV + 1),
  localparam int DATA_W = 1 + N_CH * VAL_W,
  localparam int EV_W   = IDX_W + DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acq_start,
  input  logic              acq_stop,
  input  logic              conv_done,
  input  logic              token_in,
  output logic              token_out,
  input  logic [ID_W-1:0]   chip_id,
  input  logic [CNT_W-1:0]  ev_count,
  output logic [IDX_W-1:0]  mem_addr,
  input  logic [DATA_W-1:0] mem_rd_data,
  output logic              tx_on,
  output logic              sdata,
  output logic [1:0]        mode
);

  logic load_hdr, load_evt, shift_en;
  logic last_bit, last_event;
  logic [IDX_W-1:0] rd_idx;

  ro_seq_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .acq_start  (acq_start),
    .acq_stop   (acq_stop),
    .conv_done  (conv_done),
    .token_in   (token_in),
    .ev_zero    (ev_count == '0),
    .last_bit   (last_bit),
    .last_event (last_event),
    .load_hdr   (load_hdr),
    .load_evt   (load_evt),
    .shift_en   (shift_en),
    .tx_on      (tx_on),
    .token_out  (token_out),
    .mode       (mode)
  );

  ro_event_cursor #(.MAX_EV(MAX_EV)) u_cursor (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_hdr   (load_hdr),
    .load_evt   (load_evt),
    .ev_count   (ev_count),
    .rd_idx     (rd_idx),
    .last_event (last_event)
  );

  ro_bit_shifter #(.ID_W(ID_W), .EV_W(EV_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_hdr (load_hdr),
    .load_evt (load_evt),
    .shift_en (shift_en),
    .tx_on    (tx_on),
    .hdr_word (chip_id),
    .evt_word ({rd_idx, mem_rd_data}),
    .last_bit (last_bit),
    .sdata    (sdata)
  );

  assign mem_addr = rd_idx;

  // R3: never transmit and hand on the token in the same cycle
  p_excl_tx_token_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_on && token_out));

endmodule

// File: tb/chain_readout_ctrl_test.sv
module chain_readout_ctrl_test;

  localparam int CLK_PERIOD = 10;
  localparam int ID_W   = 8;
  localparam int DATA_W = 17;
  localparam int EV_BITS = 21;

  logic clk = 1'b0;
  logic rst_n;
  logic acq_start, acq_stop, conv_done, token_in;
  logic token_out, tx_on, sdata;
  logic [7:0]  chip_id;
  logic [4:0]  ev_count;
  logic [3:0]  mem_addr;
  logic [16:0] mem_rd_data;
  logic [1:0]  mode;
  int seed;
  int n_checks = 0;
  int n_errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  chain_readout_ctrl uut (
    .clk(clk), .rst_n(rst_n), .acq_start(acq_start), .acq_stop(acq_stop),
    .conv_done(conv_done), .token_in(token_in), .token_out(token_out),
    .chip_id(chip_id), .ev_count(ev_count), .mem_addr(mem_addr),
    .mem_rd_data(mem_rd_data), .tx_on(tx_on), .sdata(sdata), .mode(mode)
  );

  function automatic logic [16:0] mem_word(input logic [3:0] a, input int s);
    logic [31:0] t;
    t = 32'(a) * 32'd2731 + 32'(s) * 32'd977 + 32'd123;
    return t[16:0];
  endfunction

  assign mem_rd_data = mem_word(mem_addr, seed);

  function automatic logic exp_bit(input int i, input logic [7:0] id, input int s);
    logic [20:0] w;
    int j, e, k;
    if (i < ID_W) return id[ID_W-1-i];
    j = i - ID_W;
    e = j / EV_BITS;
    k = j % EV_BITS;
    w = {4'(e), mem_word(4'(e), s)};
    return w[EV_BITS-1-k];
  endfunction

  task automatic check(input logic ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  endtask

  task automatic pulse(ref logic sig);
    sig = 1'b1;
    @(negedge clk);
    sig = 1'b0;
  endtask

  task automatic acquire_and_convert(input string tag);
    pulse(acq_start);
    check(mode == 2'd1, "R2", {tag, " mode after start"}, mode, 1);
    pulse(acq_stop);
    check(mode == 2'd2, "R2", {tag, " mode after stop"}, mode, 2);
    pulse(conv_done);
    check(mode == 2'd0, "R2", {tag, " mode after conversion"}, mode, 0);
  endtask

  task automatic run_chain(input int n, input logic [7:0] id, input int s,
                           input string tag);
    int len, hdr_bad, evt_bad, mode_bad, eff;
    seed = s;
    chip_id = id;
    ev_count = 5'(n);
    acquire_and_convert(tag);
    pulse(token_in);
    len = 0; hdr_bad = 0; evt_bad = 0; mode_bad = 0;
    while (tx_on && len < 600) begin
      if (sdata !== exp_bit(len, id, s)) begin
        if (len < ID_W) hdr_bad++; else evt_bad++;
      end
      if (mode != 2'd3) mode_bad++;
      len++;
      @(negedge clk);
    end
    eff = (n > 16) ? 16 : n;
    if (n == 0)
      check(len == 0, "R4", {tag, " no transmit for empty chip"}, len, 0);
    else if (n > 16)
      check(len == ID_W + EV_BITS*eff, "R10", {tag, " clamped length"}, len, ID_W + EV_BITS*eff);
    else
      check(len == ID_W + EV_BITS*eff, "R5", {tag, " transmit length"}, len, ID_W + EV_BITS*eff);
    if (eff > 0) begin
      check(mode_bad == 0, "R5", {tag, " mode during transmit"}, mode_bad, 0);
      check(hdr_bad == 0, "R6", {tag, " identifier bits"}, hdr_bad, 0);
      check(evt_bad == 0, "R7", {tag, " event bits"}, evt_bad, 0);
    end
    check(token_out == 1'b1, (n == 0) ? "R4" : "R8", {tag, " token passed"}, token_out, 1);
    check(sdata == 1'b0 && tx_on == 1'b0, "R9", {tag, " line quiet at hand-off"}, sdata, 0);
    @(negedge clk);
    check(token_out == 1'b0, "R8", {tag, " token single cycle"}, token_out, 0);
    pulse(token_in);
    check(!tx_on && !token_out, "R8", {tag, " token ignored after hand-off"},
          {tx_on, token_out}, 0);
    @(negedge clk);
    check(!tx_on && !token_out && sdata == 1'b0, "R8", {tag, " still disarmed"},
          {tx_on, token_out, sdata}, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    acq_start = 0; acq_stop = 0; conv_done = 0; token_in = 0;
    chip_id = 8'h00; ev_count = 5'd0; seed = 0;
    repeat (3) @(negedge clk);
    check(mode == 2'd0 && !tx_on && !sdata && !token_out, "R1", "state in reset",
          {mode, tx_on, sdata, token_out}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(mode == 2'd0 && !tx_on && !sdata && !token_out, "R1", "state after reset",
          {mode, tx_on, sdata, token_out}, 0);

    // R3: tokens outside the armed wait
    ev_count = 5'd3;
    pulse(token_in);
    check(!tx_on && !token_out && mode == 2'd0, "R3", "token in idle",
          {tx_on, token_out, mode}, 0);
    pulse(acq_start);
    pulse(token_in);
    check(!tx_on && !token_out && mode == 2'd1, "R3", "token in acquisition",
          {tx_on, token_out, mode}, 1);
    pulse(acq_stop);
    pulse(token_in);
    check(!tx_on && !token_out && mode == 2'd2, "R3", "token in conversion",
          {tx_on, token_out, mode}, 2);
    pulse(conv_done);
    check(mode == 2'd0, "R2", "armed idle", mode, 0);
    ev_count = 5'd0;
    pulse(token_in);
    check(token_out && !tx_on, "R4", "empty chip passes token", {token_out, tx_on}, 2);
    @(negedge clk);

    // sweep of event counts; every run after the first relies on R11 re-arming
    for (int n = 0; n <= 16; n++) begin
      run_chain(n, 8'(8'hA5 ^ (n * 29)), n * 3 + 1, (n == 0) ? "first run" : "R11 rerun");
    end
    run_chain(20, 8'h3C, 77, "R11 over-range");
    run_chain(31, 8'hFF, 5,  "R11 max count");
    finish_run();
  end

endmodule